// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block takes one fixed-point sample per cycle and re-expresses it in a different fixed-point format. The input format is set by its total width, its integer width and its signedness. The output format is set the same way. The output has total width `OUT_W`, integer width `OUT_I` (at most `OUT_W`) and therefore `OUT_W - OUT_I` fraction bits. The binary points of the two formats are lined up first. The block then removes or appends fraction bits, and fraction bits that are removed are resolved by one of seven quantization rules. Last, a value that lands outside the output range is handled by one of five overflow rules. The wrap rules can pin a parameterised number of top bits (`SAT_BITS`).

Both rules are picked per sample on select inputs, and the all-zero selects give plain truncation with plain wrap-around. The result and a valid strobe come out of a single register stage. That makes the block easy to place between a wide accumulator and a narrower consumer, such as a filter output being reduced to an 18-bit word with 12 fraction bits.

Top module: `fxp_requant`

## Requirements
- R1: An input code is read as an `IN_W`-bit number with `IN_W-IN_I` fraction bits, two's complement when `IN_SIGNED` is 1. An output code `c` means `c * 2^-(OUT_W-OUT_I)`. Whenever the input value is exactly representable in the output format, every mode pair returns that value unchanged.
- R2: `q_mode` 0 rounds toward minus infinity (plain truncation). `q_mode` 1 rounds toward zero. `q_mode` 7 behaves exactly like 0.
- R3: `q_mode` 2 to 5 round to the nearest output step. They differ only on an exact half step, which goes toward plus infinity for 2, toward zero for 3, toward minus infinity for 4 and away from zero for 5.
- R4: `q_mode` 6 rounds to the nearest output step and sends an exact half step to the neighbour whose last bit is 0.
- R5: Quantization is applied before the range test. A value just below the output maximum that rounds up past it is treated as an overflow by the selected `o_mode`.
- R6: `o_mode` 0 keeps the low `OUT_W` bits of the quantized value when `SAT_BITS` is 0. `o_mode` 5, 6 and 7 behave exactly like 0.
- R7: With `SAT_BITS = N > 0`, a wrap that overflows keeps the low `OUT_W-N` bits and forces the top `N` bits. For a signed output, a value above the range gets a 0 sign bit followed by `N-1` ones, and a value below the range gets a 1 sign bit followed by `N-1` zeros. For an unsigned output, the top `N` bits become all ones above the range and all zeros below it.
- R8: `o_mode` 1 clamps an out-of-range value to the output maximum or minimum. `o_mode` 2 replaces an out-of-range value with 0.
- R9: `o_mode` 3 clamps like `o_mode` 1, but a signed result below the range becomes minus the maximum (the most negative code is never produced by clamping).
- R10: `o_mode` 4 with a signed output and an overflow returns the input's sign applied to its magnitude taken modulo `2^(OUT_W-1)`. When `N >= 2`, the top `N-1` magnitude bits are forced to 1 first.
- R11: `out_valid` equals `in_valid` one clock earlier. `out_data` takes the new result one clock after a valid input and holds its value while `in_valid` is low. Synchronous `rst` clears both outputs to 0.
- R12: For an unsigned output the range is 0 to `2^OUT_W-1`. There, `o_mode` 3 acts as `o_mode` 1 and `o_mode` 4 acts as `o_mode` 0. A zero input always yields a zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_data | input | IN_W | Input fixed-point code |
| q_mode | input | 3 | Quantization rule select |
| o_mode | input | 3 | Overflow rule select |
| out_valid | output | 1 | Registered result valid |
| out_data | output | OUT_W | Registered output fixed-point code |

## Verification
The bench builds three small instances side by side.

The first two turn a signed 8-bit input with 4 fraction bits into a signed 5-bit output with 2 fraction bits, one with no pinned bits and one with two. Every input code is swept against all 64 mode pairs, so every half-step tie, every rounding carry into overflow and every wrap pattern is reached.

The third turns an unsigned 6-bit input with 1 fraction bit into an unsigned 6-bit output with 3 fraction bits and one pinned bit. It covers the case where fraction bits are appended rather than dropped, as well as the unsigned range rules.

// File: rtl/fxp_requant_pkg.sv
package fxp_requant_pkg;

    // quantization rule selects
    localparam logic [2:0] QM_FLOOR     = 3'd0;
    localparam logic [2:0] QM_TO_ZERO   = 3'd1;
    localparam logic [2:0] QM_HALF_UP   = 3'd2;
    localparam logic [2:0] QM_HALF_ZERO = 3'd3;
    localparam logic [2:0] QM_HALF_DOWN = 3'd4;
    localparam logic [2:0] QM_HALF_AWAY = 3'd5;
    localparam logic [2:0] QM_HALF_EVEN = 3'd6;

    // overflow rule selects
    localparam logic [2:0] OM_WRAP       = 3'd0;
    localparam logic [2:0] OM_CLAMP      = 3'd1;
    localparam logic [2:0] OM_CLAMP_ZERO = 3'd2;
    localparam logic [2:0] OM_CLAMP_SYM  = 3'd3;
    localparam logic [2:0] OM_WRAP_SM    = 3'd4;

    // mask with the top 'count' bits of a 'width'-bit field set
    function automatic logic [63:0] top_ones(int width, int count);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < width && i >= width - count) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fxp_align_round.sv
module fxp_align_round
    import fxp_requant_pkg::*;
#(
    parameter int IN_W      = 24,
    parameter bit IN_SIGNED = 1'b1,
    parameter int SHIFT     = 4,
    parameter int QW        = 30
) (
    input  logic [IN_W-1:0]       in_data,
    input  logic [2:0]            q_mode,
    output logic signed [QW-1:0]  q_val
);

    localparam int EW   = IN_W + 1;
    localparam int PADW = QW - EW;

    logic signed [EW-1:0] ext_s;
    logic signed [QW-1:0] base;
    logic                 half_bit;
    logic                 tail_nz;
    logic                 neg;
    logic                 bump;

    // one extra top bit makes signed and unsigned inputs uniform
    assign ext_s = {(IN_SIGNED && in_data[IN_W-1]), in_data};

    generate
        if (SHIFT > 0) begin : g_drop
            logic signed [EW-1:0] fl_e;
            assign fl_e     = ext_s >>> SHIFT;
            assign base     = {{PADW{fl_e[EW-1]}}, fl_e};
            assign half_bit = ext_s[SHIFT-1];
            if (SHIFT > 1) begin : g_tail
                assign tail_nz = |ext_s[SHIFT-2:0];
            end else begin : g_notail
                assign tail_nz = 1'b0;
            end
        end else begin : g_keep
            assign base     = {{PADW{ext_s[EW-1]}}, ext_s} <<< (-SHIFT);
            assign half_bit = 1'b0;
            assign tail_nz  = 1'b0;
        end
    endgenerate

    always_comb begin
        neg = ext_s[EW-1];
        unique case (q_mode)
            QM_TO_ZERO:   bump = neg & (half_bit | tail_nz);
            QM_HALF_UP:   bump = half_bit;
            QM_HALF_ZERO: bump = half_bit & (tail_nz | neg);
            QM_HALF_DOWN: bump = half_bit & tail_nz;
            QM_HALF_AWAY: bump = half_bit & (tail_nz | ~neg);
            QM_HALF_EVEN: bump = half_bit & (tail_nz | base[0]);
            default:      bump = 1'b0;
        endcase
        q_val = base + {{(QW-1){1'b0}}, bump};
    end

endmodule

// File: rtl/fxp_range_fix.sv
module fxp_range_fix
    import fxp_requant_pkg::*;
#(
    parameter int OUT_W      = 18,
    parameter bit OUT_SIGNED = 1'b1,
    parameter int SAT_BITS   = 0,
    parameter int QW         = 30
) (
    input  logic signed [QW-1:0] q_val,
    input  logic [2:0]           o_mode,
    output logic [OUT_W-1:0]     res
);

    localparam logic signed [63:0] HI = OUT_SIGNED ? (64'sd1 <<< (OUT_W-1)) - 64'sd1
                                                   : (64'sd1 <<< OUT_W) - 64'sd1;
    localparam logic signed [63:0] LO = OUT_SIGNED ? -(64'sd1 <<< (OUT_W-1)) : 64'sd0;
    localparam logic signed [63:0] SYM = OUT_SIGNED ? -HI : LO;
    localparam logic [63:0] WMASK64 = top_ones(OUT_W, SAT_BITS);
    localparam logic [63:0] MMASK64 = top_ones(OUT_W-1, (SAT_BITS > 1) ? SAT_BITS-1 : 0);

    localparam logic [OUT_W-1:0] SATMSK   = WMASK64[OUT_W-1:0];
    localparam logic [OUT_W-2:0] MAGMSK   = MMASK64[OUT_W-2:0];
    localparam logic [OUT_W-1:0] SIGNBIT  = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] HI_CODE  = HI[OUT_W-1:0];
    localparam logic [OUT_W-1:0] LO_CODE  = LO[OUT_W-1:0];
    localparam logic [OUT_W-1:0] SYM_CODE = SYM[OUT_W-1:0];

    logic signed [63:0]  q64;
    logic                neg;
    logic                ovf_hi;
    logic                ovf_lo;
    logic                ovf;
    logic [OUT_W-1:0]    wl;
    logic [OUT_W-1:0]    wrap_n;
    logic [OUT_W-1:0]    pin;
    logic [OUT_W-2:0]    mag_raw;
    logic [OUT_W-2:0]    mag;
    logic [OUT_W-1:0]    sm;

    always_comb begin
        q64    = {{(64-QW){q_val[QW-1]}}, q_val};
        neg    = q_val[QW-1];
        ovf_hi = q64 > HI;
        ovf_lo = q64 < LO;
        ovf    = ovf_hi | ovf_lo;
        wl     = q64[OUT_W-1:0];

        // wrap with pinned top bits
        if (OUT_SIGNED) pin = ovf_hi ? (SATMSK & ~SIGNBIT) : SIGNBIT;
        else            pin = ovf_hi ? SATMSK : '0;
        if (SAT_BITS > 0 && ovf) wrap_n = (wl & ~SATMSK) | pin;
        else                     wrap_n = wl;

        // sign-magnitude wrap
        mag_raw = neg ? (~q64[OUT_W-2:0] + 1'b1) : q64[OUT_W-2:0];
        mag     = mag_raw | MAGMSK;
        sm      = neg ? (~{1'b0, mag} + 1'b1) : {1'b0, mag};

        res = wl;
        if (ovf) begin
            unique case (o_mode)
                OM_CLAMP:      res = ovf_hi ? HI_CODE : LO_CODE;
                OM_CLAMP_ZERO: res = '0;
                OM_CLAMP_SYM:  res = ovf_hi ? HI_CODE : SYM_CODE;
                OM_WRAP_SM:    res = OUT_SIGNED ? sm : wrap_n;
                default:       res = wrap_n;
            endcase
        end
    end

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
    import fxp_requant_pkg::*;
#(
    parameter int IN_W       = 24,
    parameter int IN_I       = 8,
    parameter bit IN_SIGNED  = 1'b1,
    parameter int OUT_W      = 18,
    parameter int OUT_I      = 6,
    parameter bit OUT_SIGNED = 1'b1,
    parameter int SAT_BITS   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic [2:0]       q_mode,
    input  logic [2:0]       o_mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    localparam int IN_F      = IN_W - IN_I;
    localparam int OUT_F     = OUT_W - OUT_I;
    localparam int SHIFT     = IN_F - OUT_F;
    localparam int ABS_SHIFT = (SHIFT < 0) ? -SHIFT : SHIFT;
    localparam int QW        = IN_W + 2 + ABS_SHIFT;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] dat;
    } stage_t;

    stage_t               st_d;
    stage_t               st_q;
    logic signed [QW-1:0] q_val;
    logic [OUT_W-1:0]     fixed_val;

    fxp_align_round #(
        .IN_W      (IN_W),
        .IN_SIGNED (IN_SIGNED),
        .SHIFT     (SHIFT),
        .QW        (QW)
    ) u_align (
        .in_data (in_data),
        .q_mode  (q_mode),
        .q_val   (q_val)
    );

    fxp_range_fix #(
        .OUT_W      (OUT_W),
        .OUT_SIGNED (OUT_SIGNED),
        .SAT_BITS   (SAT_BITS),
        .QW         (QW)
    ) u_range (
        .q_val  (q_val),
        .o_mode (o_mode),
        .res    (fixed_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.dat = fixed_val;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

endmodule

// File: rtl/fxp_requant_chk.sv
module fxp_requant_chk
    import fxp_requant_pkg::*;
#(
    parameter int IN_W       = 24,
    parameter bit IN_SIGNED  = 1'b1,
    parameter int OUT_W      = 18,
    parameter bit OUT_SIGNED = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic [2:0]       o_mode,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    logic in_nonneg;
    logic clamping;
    assign in_nonneg = !IN_SIGNED || !in_data[IN_W-1];
    assign clamping  = (o_mode == OM_CLAMP) || (o_mode == OM_CLAMP_ZERO) || (o_mode == OM_CLAMP_SYM);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_data == '0)); // R11

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R11

    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == '0) |=> (out_data == '0)); // R12

    AST_CLAMP_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && OUT_SIGNED && in_nonneg && clamping) |=> !out_data[OUT_W-1]); // R8

endmodule

bind fxp_requant fxp_requant_chk #(
    .IN_W       (IN_W),
    .IN_SIGNED  (IN_SIGNED),
    .OUT_W      (OUT_W),
    .OUT_SIGNED (OUT_SIGNED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .o_mode    (o_mode),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_fxp_requant.sv
`timescale 1ns/1ps
module tb_fxp_requant;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] din_s = '0;
    logic [5:0] din_u = '0;
    logic [2:0] qm = '0;
    logic [2:0] om = '0;
    logic       v_a, v_b, v_c;
    logic [4:0] d_a, d_b;
    logic [5:0] d_c;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fxp_requant #(.IN_W(8), .IN_I(4), .IN_SIGNED(1'b1), .OUT_W(5), .OUT_I(3),
                  .OUT_SIGNED(1'b1), .SAT_BITS(0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din_s),
        .q_mode(qm), .o_mode(om), .out_valid(v_a), .out_data(d_a));

    fxp_requant #(.IN_W(8), .IN_I(4), .IN_SIGNED(1'b1), .OUT_W(5), .OUT_I(3),
                  .OUT_SIGNED(1'b1), .SAT_BITS(2)) dut_pin2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din_s),
        .q_mode(qm), .o_mode(om), .out_valid(v_b), .out_data(d_b));

    fxp_requant #(.IN_W(6), .IN_I(5), .IN_SIGNED(1'b0), .OUT_W(6), .OUT_I(3),
                  .OUT_SIGNED(1'b0), .SAT_BITS(1)) dut_uns (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(din_u),
        .q_mode(qm), .o_mode(om), .out_valid(v_c), .out_data(d_c));

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint pw(int k);
        return 64'sd1 <<< k;
    endfunction

    function automatic longint pmod(longint a, longint m);
        return ((a % m) + m) % m;
    endfunction

    // arithmetic reference: returns the output code, flags overflow
    function automatic longint model(longint code, int iw, int ifr, bit isg, int ow, int ofr,
                                     bit osg, int n, int q_sel, int o_sel, output bit ovf);
        longint x, p, fl, rem, q, lo, hi, low, mag, r;
        int d;
        x = code;
        if (isg && code >= pw(iw-1)) x = code - pw(iw);
        d = ifr - ofr;
        if (d >= 0) begin
            p   = pw(d);
            fl  = (x >= 0) ? x / p : -((-x + p - 1) / p);
            rem = x - fl * p;
            case (q_sel)
                1: q = (x < 0 && rem != 0) ? fl + 1 : fl;
                2: q = (2*rem >= p) ? fl + 1 : fl;
                3: q = (2*rem > p || (2*rem == p && x < 0)) ? fl + 1 : fl;
                4: q = (2*rem > p) ? fl + 1 : fl;
                5: q = (2*rem > p || (2*rem == p && x >= 0)) ? fl + 1 : fl;
                6: q = (2*rem > p || (2*rem == p && (fl % 2) != 0)) ? fl + 1 : fl;
                default: q = fl;
            endcase
        end else begin
            q = x * pw(-d);
        end
        hi  = osg ? pw(ow-1) - 1 : pw(ow) - 1;
        lo  = osg ? -pw(ow-1) : 0;
        ovf = (q > hi) || (q < lo);
        if (!ovf) r = q;
        else begin
            r = pmod(q, pw(ow));
            if (n > 0) begin
                low = pmod(q, pw(ow-n));
                if (osg) r = (q > hi) ? (pw(n-1) - 1) * pw(ow-n) + low : -pw(ow-1) + low;
                else     r = (q > hi) ? (pw(n) - 1) * pw(ow-n) + low : low;
            end
            case (o_sel)
                1: r = (q > hi) ? hi : lo;
                2: r = 0;
                3: r = (q > hi) ? hi : (osg ? -hi : lo);
                4: if (osg) begin
                       mag = ((q < 0) ? -q : q) % pw(ow-1);
                       if (n >= 2) mag = (mag % pw(ow-n)) + (pw(n-1) - 1) * pw(ow-n);
                       r = (q < 0) ? -mag : mag;
                   end
                default: ;
            endcase
        end
        return r & (pw(ow) - 1);
    endfunction

    function automatic string tag_for(bit ovf, int q_sel, int o_sel, int n, bit osg);
        if (ovf) begin
            if (!osg) return "R12";
            if (o_sel == 1 || o_sel == 2) return "R8";
            if (o_sel == 3) return "R9";
            if (o_sel == 4) return "R10";
            return (n > 0) ? "R7" : "R6";
        end
        if (q_sel == 6) return "R4";
        if (q_sel >= 2 && q_sel <= 5) return "R3";
        return "R2";
    endfunction

    task automatic drive(logic [7:0] s, logic [5:0] u, logic [2:0] qs, logic [2:0] os);
        in_valid = 1'b1;
        din_s = s;
        din_u = u;
        qm = qs;
        om = os;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        longint exp_v;
        bit     ovf;
        logic [4:0] last_a;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset valid a", v_a, 0);
        check("R11", "reset data a", d_a, 0);
        check("R11", "reset data c", d_c, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11", "idle valid after reset", v_a, 0);

        // R1: exact values pass through
        drive(8'h18, 6'd3, 3'd0, 3'd0);
        check("R1", "1.5 signed exact", d_a, 6);
        check("R1", "1.5 unsigned appended fraction", d_c, 12);
        check("R11", "valid one cycle later", v_a, 1);
        drive(8'hE8, 6'd0, 3'd5, 3'd1);
        check("R1", "-1.5 signed exact", d_a, 5'h1A);

        // R5: rounding carry crosses the maximum
        drive(8'd62, 6'd0, 3'd2, 3'd1);
        check("R5", "round up then clamp", d_a, 15);
        drive(8'd62, 6'd0, 3'd2, 3'd0);
        check("R5", "round up then wrap", d_a, 5'h10);
        drive(8'd62, 6'd0, 3'd2, 3'd2);
        check("R5", "round up then clamp to zero", d_a, 0);
        drive(8'd62, 6'd0, 3'd0, 3'd2);
        check("R5", "truncate stays in range", d_a, 15);

        // full sweep of codes and mode pairs
        for (int o_sel = 0; o_sel < 8; o_sel++) begin
            for (int q_sel = 0; q_sel < 8; q_sel++) begin
                for (int v = 0; v < 256; v++) begin
                    drive(8'(v), 6'(v), 3'(q_sel), 3'(o_sel));
                    exp_v = model(longint'(v), 8, 4, 1'b1, 5, 2, 1'b1, 0, q_sel, o_sel, ovf);
                    check(tag_for(ovf, q_sel, o_sel, 0, 1'b1), "sweep pin0", d_a, exp_v);
                    exp_v = model(longint'(v), 8, 4, 1'b1, 5, 2, 1'b1, 2, q_sel, o_sel, ovf);
                    check(tag_for(ovf, q_sel, o_sel, 2, 1'b1), "sweep pin2", d_b, exp_v);
                    exp_v = model(longint'(v % 64), 6, 1, 1'b0, 6, 3, 1'b0, 1, q_sel, o_sel, ovf);
                    check(ovf ? "R12" : "R1", "sweep unsigned", d_c, exp_v);
                    if (v == 0) check("R11", "valid during stream", v_b, 1);
                end
            end
        end

        // R11: idle input leaves the output untouched
        last_a = d_a;
        in_valid = 1'b0;
        din_s = 8'h55;
        din_u = 6'h2A;
        om = 3'd1;
        @(negedge clk);
        check("R11", "idle clears valid", v_a, 0);
        check("R11", "idle holds data", d_a, last_a);
        din_s = 8'h80;
        @(negedge clk);
        check("R11", "idle still holds data", d_a, last_a);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule